// File: doc/BRIEF.md
# Fetch-Stage Branch Target Predictor with Hit-Gated Detection

This unit sits beside the fetch program counter. For each fetch it returns the address to fetch next. It holds three structures: a small direct-mapped branch target buffer (BTB), an eight-entry return stack, and a tagless table of indirect targets. Every request looks up the BTB, even when the stack or the indirect table will supply the final address.

A static configuration input chooses how branches are recognised:

- **Require-hit mode** models a wide front end. A branch exists only when the BTB hits, and its kind is taken from the kind field stored in the BTB entry.
- **Pre-decode mode** models a simple front end. The kind bits that arrive with the fetch are trusted, with or without a BTB hit.

The return stack and the indirect table act only while a branch is detected.

A resolve port reports each executed branch: its address, kind, actual direction, correct target, whether it was mispredicted, and whether it hit the BTB when it was predicted. From this port the unit trains its tables and raises a one-cycle BTB-miss event.

Branch kinds use the same encoding everywhere: 0 = direct jump, 1 = call, 2 = return, 3 = indirect jump. Calls count as direct branches.

Top module: `fetch_target_pred`

## Requirements
- R1: After a synchronous active-low reset, the BTB, stack and indirect table are empty and `miss_evt` is low. In require-hit mode every request then predicts PC+4. In pre-decode mode a pre-decoded return then predicts PC+4.
- R2: The BTB index is word-address bits [3:0] (PC bits [5:2]) and the tag is PC bits [31:6]. A hit needs a valid entry and a matching tag. A direct jump that hits, with the taken hint set, predicts the stored target. With the hint clear it predicts PC+4. A tag mismatch at the same index predicts PC+4 in require-hit mode.
- R3: In require-hit mode, a BTB miss makes the pre-decoded kind irrelevant. There is no push, no pop and no indirect lookup, and the prediction is PC+4.
- R4: In require-hit mode, the kind stored in the hitting BTB entry drives the stack operation and the pre-decoded bits are ignored. A call that hits predicts its stored target and pushes PC+4. A return that hits pops the top entry as its prediction.
- R5: In pre-decode mode, a pre-decoded call pushes PC+4 and a pre-decoded return pops, whether or not the BTB hits.
- R6: The stack holds 8 entries. A push onto a full stack overwrites the oldest entry. A return on an empty stack predicts PC+4 and leaves the stack empty.
- R7: The indirect table is read only for a detected indirect jump (kind 3) with the taken hint set. A trained table entry takes precedence over the BTB target. An indirect jump with the hint clear predicts PC+4.
- R8: Every resolve of kind 3 writes its correct target into the indirect-table entry at the BTB-style index. This happens whether or not the jump was mispredicted.
- R9: In require-hit mode, a resolve that was taken and mispredicted writes the BTB with the correct target and kind, for every kind including returns and indirect jumps.
- R10: In pre-decode mode, a taken, mispredicted resolve writes the BTB only for kinds 0 and 1. Kinds 2 and 3 are written only when the indirect table is absent, and kind 2 never. In either mode, a resolve that is not taken or not mispredicted never writes the BTB.
- R11: `miss_evt` is high for exactly the one cycle after a resolve that was taken, mispredicted and had missed the BTB. It stays low after any other resolve.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_need_hit | input | 1 | 1 = require-hit mode, 0 = pre-decode mode (static) |
| req_valid | input | 1 | A prediction request is present |
| req_pc | input | 32 | Fetch address (word aligned) |
| req_is_br | input | 1 | Pre-decode marks the fetch as a branch |
| req_kind | input | 2 | Pre-decoded branch kind |
| req_taken | input | 1 | Direction hint for direct and indirect jumps |
| res_valid | input | 1 | A resolved branch is reported |
| res_pc | input | 30 | Word address of the resolved branch |
| res_kind | input | 2 | Kind of the resolved branch |
| res_taken | input | 1 | Branch was actually taken |
| res_mispred | input | 1 | Branch was mispredicted |
| res_btb_hit | input | 1 | Branch hit the BTB when predicted |
| res_target | input | 32 | Correct target address |
| pred_npc | output | 32 | Predicted next fetch address (combinational) |
| miss_evt | output | 1 | One-cycle BTB-miss event |

## Verification
A corrupt BTB entry, tag or kind shows on `pred_npc` in the same cycle as the next fetch to that index. It appears as a wrong target, as PC+4 where a target was due, or as a stack action of the wrong kind. A stack pointer or occupancy count that is off becomes visible only at a later return, which pops the wrong address or falls through too early or too late. For that reason the stack is filled past its depth and then drained one entry beyond empty. A wrong indirect-table entry is seen only on a taken indirect fetch that is detected. `miss_evt` errors appear one cycle after the resolve that caused them.

// File: rtl/fpred_pkg.sv
// Package: shared branch-kind encoding and address constants for the
// fetch target predictor. Assumes 4-byte aligned instructions.
package fpred_pkg;
    typedef enum logic [1:0] {
        BK_DIRECT   = 2'd0,
        BK_CALL     = 2'd1,
        BK_RETURN   = 2'd2,
        BK_INDIRECT = 2'd3
    } br_kind_e;

    localparam int unsigned WORD_SHIFT = 2;
endpackage

// File: rtl/fpred_btb.sv
// Direct-mapped branch target buffer. Lookup is combinational on a
// word address; a single write port installs an entry at the clock.
// Assumes ENTRIES is a power of two. Only valid bits are reset.
module fpred_btb #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned AW      = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-3:0]         lk_wa,
    output logic                  lk_hit,
    output logic [1:0]            lk_kind,
    output logic [AW-1:0]         lk_target,
    input  logic                  wr_en,
    input  logic [AW-3:0]         wr_wa,
    input  logic [1:0]            wr_kind,
    input  logic [AW-1:0]         wr_target
);
    localparam int unsigned WA = AW - 2;
    localparam int unsigned IW = $clog2(ENTRIES);
    localparam int unsigned TW = WA - IW;

    logic [ENTRIES-1:0] vld_q;
    logic [TW-1:0]      tag_q  [ENTRIES];
    logic [1:0]         kind_q [ENTRIES];
    logic [AW-1:0]      tgt_q  [ENTRIES];

    logic [IW-1:0] lk_idx, wr_idx;
    assign lk_idx = lk_wa[IW-1:0];
    assign wr_idx = wr_wa[IW-1:0];

    // Valid bits: cleared by reset, set by an install.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (wr_en) begin
            vld_q[wr_idx] <= 1'b1;
        end
    end

    // Entry payload: tag, kind and target written on install.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx]  <= wr_wa[WA-1:IW];
            kind_q[wr_idx] <= wr_kind;
            tgt_q[wr_idx]  <= wr_target;
        end
    end

    // Lookup: hit needs a valid entry with a matching tag.
    always_comb begin
        lk_hit    = vld_q[lk_idx] && (tag_q[lk_idx] == lk_wa[WA-1:IW]);
        lk_kind   = kind_q[lk_idx];
        lk_target = tgt_q[lk_idx];
    end
endmodule

// File: rtl/fpred_ras.sv
// Circular return address stack. A push on a full stack overwrites the
// oldest entry; a pop on an empty stack does nothing. The top entry and
// an occupancy count are visible combinationally. Assumes DEPTH is a
// power of two and that push and pop are never requested together.
module fpred_ras #(
    parameter int unsigned DEPTH = 8,
    parameter int unsigned AW    = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         push,
    input  logic [AW-1:0]                push_addr,
    input  logic                         pop,
    output logic                         top_valid,
    output logic [AW-1:0]                top_addr,
    output logic [$clog2(DEPTH+1)-1:0]   cnt
);
    localparam int unsigned PW = $clog2(DEPTH);
    localparam int unsigned CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] FULL = CW'(DEPTH);

    logic [AW-1:0] stk_q [DEPTH];
    logic [PW-1:0] ptr_q;
    logic [CW-1:0] cnt_q;
    logic [PW-1:0] top_ptr;

    assign top_ptr = ptr_q - PW'(1);

    // Pointer and occupancy: advance on push, retreat on a non-empty pop.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ptr_q <= '0;
            cnt_q <= '0;
        end else if (push) begin
            ptr_q <= ptr_q + PW'(1);
            if (cnt_q != FULL) cnt_q <= cnt_q + CW'(1);
        end else if (pop && (cnt_q != '0)) begin
            ptr_q <= top_ptr;
            cnt_q <= cnt_q - CW'(1);
        end
    end

    // Storage: a push writes the slot the pointer names.
    always_ff @(posedge clk) begin
        if (push) stk_q[ptr_q] <= push_addr;
    end

    // Outputs: the most recent entry and the occupancy.
    always_comb begin
        top_valid = (cnt_q != '0);
        top_addr  = stk_q[top_ptr];
        cnt       = cnt_q;
    end
endmodule

// File: rtl/fpred_ind.sv
// Tagless indirect target table with a valid bit per entry. Indexed by
// the low word-address bits; trained on every resolved indirect jump.
module fpred_ind #(
    parameter int unsigned ENTRIES = 16,
    parameter int unsigned AW      = 32
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [$clog2(ENTRIES)-1:0]   lk_idx,
    output logic                         lk_valid,
    output logic [AW-1:0]                lk_target,
    input  logic                         tr_en,
    input  logic [$clog2(ENTRIES)-1:0]   tr_idx,
    input  logic [AW-1:0]                tr_target
);
    logic [ENTRIES-1:0] vld_q;
    logic [AW-1:0]      tgt_q [ENTRIES];

    // Valid bits: cleared by reset, set by training.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
        end else if (tr_en) begin
            vld_q[tr_idx] <= 1'b1;
        end
    end

    // Target storage: written by training.
    always_ff @(posedge clk) begin
        if (tr_en) tgt_q[tr_idx] <= tr_target;
    end

    // Lookup of the indexed entry.
    always_comb begin
        lk_valid  = vld_q[lk_idx];
        lk_target = tgt_q[lk_idx];
    end
endmodule

// File: rtl/fetch_target_pred.sv
// Fetch target predictor top. Looks up the BTB on every request, forms
// a branch-detected condition from the hit and the mode input, and uses
// it to gate the return stack and indirect table. The resolve port
// installs BTB entries per the mode-dependent policy, trains the
// indirect table and raises a registered BTB-miss event.
// Assumes cfg_need_hit is held static during operation and that the
// fetch address is word aligned.
module fetch_target_pred
    import fpred_pkg::*;
#(
    parameter int unsigned AW          = 32,
    parameter int unsigned BTB_ENTRIES = 16,
    parameter int unsigned RAS_DEPTH   = 8,
    parameter int unsigned IND_ENTRIES = 16,
    parameter bit          HAS_IND     = 1'b1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_need_hit,
    input  logic          req_valid,
    input  logic [AW-1:0] req_pc,
    input  logic          req_is_br,
    input  logic [1:0]    req_kind,
    input  logic          req_taken,
    input  logic          res_valid,
    input  logic [AW-3:0] res_pc,
    input  logic [1:0]    res_kind,
    input  logic          res_taken,
    input  logic          res_mispred,
    input  logic          res_btb_hit,
    input  logic [AW-1:0] res_target,
    output logic [AW-1:0] pred_npc,
    output logic          miss_evt
);
    localparam int unsigned   IIW  = $clog2(IND_ENTRIES);
    localparam int unsigned   RCW  = $clog2(RAS_DEPTH + 1);
    localparam logic [AW-1:0] STEP = AW'(4);

    logic          btb_hit;
    logic [1:0]    btb_kind;
    logic [AW-1:0] btb_target;
    logic          btb_we;
    logic [AW-1:0] seq_pc;
    logic          br_detected;
    logic          eff_br;
    logic [1:0]    eff_kind;
    logic          is_call, is_ret, is_ind, is_dir;
    logic          ras_push, ras_pop, ras_top_vld;
    logic [AW-1:0] ras_top;
    logic [RCW-1:0] ras_cnt;
    logic          ind_vld;
    logic [AW-1:0] ind_target;
    logic          ind_train;

    assign seq_pc = req_pc + STEP;

    fpred_btb #(.ENTRIES(BTB_ENTRIES), .AW(AW)) u_btb (
        .clk       (clk),
        .rst_n     (rst_n),
        .lk_wa     (req_pc[AW-1:WORD_SHIFT]),
        .lk_hit    (btb_hit),
        .lk_kind   (btb_kind),
        .lk_target (btb_target),
        .wr_en     (btb_we),
        .wr_wa     (res_pc),
        .wr_kind   (res_kind),
        .wr_target (res_target)
    );

    fpred_ras #(.DEPTH(RAS_DEPTH), .AW(AW)) u_ras (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (ras_push),
        .push_addr (seq_pc),
        .pop       (ras_pop),
        .top_valid (ras_top_vld),
        .top_addr  (ras_top),
        .cnt       (ras_cnt)
    );

    assign ind_train = res_valid && (res_kind == BK_INDIRECT);

    generate
        if (HAS_IND) begin : g_ind
            fpred_ind #(.ENTRIES(IND_ENTRIES), .AW(AW)) u_ind (
                .clk       (clk),
                .rst_n     (rst_n),
                .lk_idx    (req_pc[WORD_SHIFT +: IIW]),
                .lk_valid  (ind_vld),
                .lk_target (ind_target),
                .tr_en     (ind_train),
                .tr_idx    (res_pc[IIW-1:0]),
                .tr_target (res_target)
            );
        end else begin : g_no_ind
            assign ind_vld    = 1'b0;
            assign ind_target = '0;
        end
    endgenerate

    // Detection: branch kind comes from the BTB in require-hit mode,
    // from pre-decode otherwise; the gate needs a hit or pre-decode mode.
    always_comb begin
        br_detected = btb_hit || !cfg_need_hit;
        eff_br      = cfg_need_hit ? btb_hit  : req_is_br;
        eff_kind    = cfg_need_hit ? btb_kind : req_kind;
        is_call = req_valid && br_detected && eff_br && (eff_kind == BK_CALL);
        is_ret  = req_valid && br_detected && eff_br && (eff_kind == BK_RETURN);
        is_ind  = req_valid && br_detected && eff_br && (eff_kind == BK_INDIRECT);
        is_dir  = req_valid && br_detected && eff_br && (eff_kind == BK_DIRECT);
        ras_push = is_call;
        ras_pop  = is_ret;
    end

    // Next-PC selection: fall through unless a detected branch has a target.
    always_comb begin
        pred_npc = seq_pc;
        if (is_call && btb_hit) begin
            pred_npc = btb_target;
        end else if (is_ret && ras_top_vld) begin
            pred_npc = ras_top;
        end else if (is_ind && req_taken) begin
            if (ind_vld)      pred_npc = ind_target;
            else if (btb_hit) pred_npc = btb_target;
        end else if (is_dir && req_taken && btb_hit) begin
            pred_npc = btb_target;
        end
    end

    // BTB install policy on a taken misprediction, chosen by the mode.
    always_comb begin
        btb_we = 1'b0;
        if (res_valid && res_taken && res_mispred) begin
            if (cfg_need_hit)
                btb_we = 1'b1;
            else if ((res_kind == BK_DIRECT) || (res_kind == BK_CALL))
                btb_we = 1'b1;
            else if (!HAS_IND && (res_kind != BK_RETURN))
                btb_we = 1'b1;
        end
    end

    // Miss event: one-cycle pulse after a taken mispredict that missed.
    always_ff @(posedge clk) begin
        if (!rst_n) miss_evt <= 1'b0;
        else        miss_evt <= res_valid && res_taken && res_mispred && !res_btb_hit;
    end
endmodule

// File: rtl/fpred_chk.sv
// Property checker for fetch_target_pred, attached with bind below.
module fpred_chk #(
    parameter int unsigned AW        = 32,
    parameter int unsigned RAS_DEPTH = 8,
    parameter bit          HAS_IND   = 1'b1
) (
    input logic                           clk,
    input logic                           rst_n,
    input logic                           cfg_need_hit,
    input logic                           req_valid,
    input logic [AW-1:0]                  req_pc,
    input logic                           res_valid,
    input logic [1:0]                     res_kind,
    input logic                           res_taken,
    input logic                           res_mispred,
    input logic                           res_btb_hit,
    input logic [AW-1:0]                  pred_npc,
    input logic                           miss_evt,
    input logic                           btb_hit,
    input logic                           btb_we,
    input logic                           ras_pop,
    input logic [$clog2(RAS_DEPTH+1)-1:0] ras_cnt
);
    localparam logic [AW-1:0] STEP = AW'(4);
    localparam int unsigned   RCW  = $clog2(RAS_DEPTH + 1);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> !miss_evt);

    // R3
    miss_falls_through_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && cfg_need_hit && !btb_hit) |-> (pred_npc == req_pc + STEP));

    // R6
    ras_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ras_cnt <= RCW'(RAS_DEPTH));

    // R6
    ras_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ras_pop && (ras_cnt == '0)) |=> (ras_cnt == '0));

    // R9
    need_hit_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_need_hit && res_valid && res_taken && res_mispred) |-> btb_we);

    // R10
    predecode_return_no_install_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_need_hit && res_valid && (res_kind == 2'd2)) |-> !btb_we);

    // R10
    no_install_when_correct_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && !(res_taken && res_mispred)) |-> !btb_we);

    // R10
    predecode_indirect_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (HAS_IND && !cfg_need_hit && res_valid && (res_kind == 2'd3)) |-> !btb_we);

    // R11
    miss_evt_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        miss_evt |-> $past(res_valid && res_taken && res_mispred && !res_btb_hit));

    // R11
    miss_evt_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(res_valid && res_taken && res_mispred && !res_btb_hit))
            |-> miss_evt);
endmodule

bind fetch_target_pred fpred_chk #(
    .AW        (AW),
    .RAS_DEPTH (RAS_DEPTH),
    .HAS_IND   (HAS_IND)
) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .cfg_need_hit (cfg_need_hit),
    .req_valid    (req_valid),
    .req_pc       (req_pc),
    .res_valid    (res_valid),
    .res_kind     (res_kind),
    .res_taken    (res_taken),
    .res_mispred  (res_mispred),
    .res_btb_hit  (res_btb_hit),
    .pred_npc     (pred_npc),
    .miss_evt     (miss_evt),
    .btb_hit      (btb_hit),
    .btb_we       (btb_we),
    .ras_pop      (ras_pop),
    .ras_cnt      (ras_cnt)
);

// File: tb/fetch_target_pred_tb.sv
// Self-checking bench: sweeps the BTB indexes, fills and drains the
// return stack, and walks both modes through the install policy.
module fetch_target_pred_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_need_hit = 1'b1;
    logic        req_valid = 1'b0;
    logic [31:0] req_pc = '0;
    logic        req_is_br = 1'b0;
    logic [1:0]  req_kind = '0;
    logic        req_taken = 1'b0;
    logic        res_valid = 1'b0;
    logic [29:0] res_pc = '0;
    logic [1:0]  res_kind = '0;
    logic        res_taken = 1'b0;
    logic        res_mispred = 1'b0;
    logic        res_btb_hit = 1'b0;
    logic [31:0] res_target = '0;
    logic [31:0] pred_npc;
    logic        miss_evt;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    localparam logic [1:0] K_DIR = 2'd0, K_CALL = 2'd1, K_RET = 2'd2, K_IND = 2'd3;

    always #4 clk = ~clk;

    fetch_target_pred dut_i (
        .clk(clk), .rst_n(rst_n), .cfg_need_hit(cfg_need_hit),
        .req_valid(req_valid), .req_pc(req_pc), .req_is_br(req_is_br),
        .req_kind(req_kind), .req_taken(req_taken),
        .res_valid(res_valid), .res_pc(res_pc), .res_kind(res_kind),
        .res_taken(res_taken), .res_mispred(res_mispred),
        .res_btb_hit(res_btb_hit), .res_target(res_target),
        .pred_npc(pred_npc), .miss_evt(miss_evt)
    );

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", rq, act, exp);
        end
    endtask

    task automatic req(input logic [31:0] pc, input logic isbr, input logic [1:0] kind,
                       input logic tk, input logic [31:0] exp, input string rq);
        @(negedge clk);
        req_valid = 1'b1; req_pc = pc; req_is_br = isbr; req_kind = kind; req_taken = tk;
        #1 chk(rq, pred_npc, exp);
        @(posedge clk);
        #1 req_valid = 1'b0;
    endtask

    task automatic res(input logic [31:0] pc, input logic [1:0] kind, input logic tk,
                       input logic mp, input logic hit, input logic [31:0] tgt,
                       input logic exp_evt, input string rq);
        @(negedge clk);
        res_valid = 1'b1; res_pc = pc[31:2]; res_kind = kind; res_taken = tk;
        res_mispred = mp; res_btb_hit = hit; res_target = tgt;
        @(posedge clk);
        #1 res_valid = 1'b0;
        chk(rq, {31'd0, miss_evt}, {31'd0, exp_evt});
    endtask

    initial begin
        #(8 * 100000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 chk("R1 miss_evt in reset", {31'd0, miss_evt}, 32'd0);
        @(negedge clk) rst_n = 1'b1;

        // R1: empty after reset, both modes
        req(32'h100, 1'b1, K_CALL, 1'b1, 32'h104, "R1 need-hit empty");
        cfg_need_hit = 1'b0;
        req(32'h200, 1'b1, K_RET, 1'b1, 32'h204, "R1 empty stack");
        cfg_need_hit = 1'b1;

        // R2/R11: fill every BTB index with a direct jump
        for (int i = 0; i < 16; i++)
            res(32'h1000 + 32'(i) * 4, K_DIR, 1'b1, 1'b1, 1'b0,
                32'h8000 + 32'(i) * 16, 1'b1, "R11 miss pulse");
        for (int i = 0; i < 16; i++) begin
            req(32'h1000 + 32'(i) * 4, 1'b0, K_DIR, 1'b1, 32'h8000 + 32'(i) * 16, "R2 hit taken");
            req(32'h1000 + 32'(i) * 4, 1'b0, K_DIR, 1'b0, 32'h1004 + 32'(i) * 4, "R2 hit not taken");
            req(32'h1040 + 32'(i) * 4, 1'b0, K_DIR, 1'b1, 32'h1044 + 32'(i) * 4, "R2 tag mismatch");
        end

        // R10/R11: not-taken or correct resolves install nothing
        res(32'h1004, K_DIR, 1'b0, 1'b1, 1'b0, 32'hEEE0, 1'b0, "R11 not taken");
        res(32'h1008, K_DIR, 1'b1, 1'b0, 1'b0, 32'hEEE0, 1'b0, "R11 not mispredicted");
        res(32'h100C, K_DIR, 1'b1, 1'b1, 1'b1, 32'h800C, 1'b0, "R11 was a hit");
        req(32'h1004, 1'b0, K_DIR, 1'b1, 32'h8010, "R10 not taken kept");
        req(32'h1008, 1'b0, K_DIR, 1'b1, 32'h8020, "R10 correct kept");

        // R3: pre-decoded call on a miss does not push
        req(32'h3004, 1'b1, K_CALL, 1'b1, 32'h3008, "R3 call miss");
        res(32'h3040, K_RET, 1'b1, 1'b1, 1'b0, 32'h0, 1'b1, "R9 return install");
        req(32'h3040, 1'b1, K_DIR, 1'b1, 32'h3044, "R3 nothing pushed");

        // R4: stored kind drives the stack
        res(32'h3088, K_CALL, 1'b1, 1'b1, 1'b0, 32'h5000, 1'b1, "R9 call install");
        req(32'h3088, 1'b0, K_DIR, 1'b0, 32'h5000, "R4 call hit target");
        req(32'h3040, 1'b0, K_DIR, 1'b0, 32'h308C, "R4 return pops");
        req(32'h3040, 1'b0, K_DIR, 1'b0, 32'h3044, "R4 stack empty again");

        // R5: pre-decode mode trusts the pre-decoded kind
        cfg_need_hit = 1'b0;
        req(32'h4010, 1'b1, K_CALL, 1'b1, 32'h4014, "R5 call miss");
        req(32'h4020, 1'b1, K_RET, 1'b1, 32'h4014, "R5 return pops");

        // R6: overflow by one, then drain past empty
        for (int i = 0; i < 9; i++)
            req(32'h6000 + 32'(i) * 32'h100, 1'b1, K_CALL, 1'b1,
                32'h6004 + 32'(i) * 32'h100, "R6 push");
        for (int j = 0; j < 8; j++)
            req(32'h7000, 1'b1, K_RET, 1'b1, 32'h6004 + 32'(8 - j) * 32'h100, "R6 pop order");
        req(32'h7000, 1'b1, K_RET, 1'b1, 32'h7004, "R6 underflow");

        // R7/R8/R10: indirect jumps
        res(32'h9030, K_IND, 1'b1, 1'b1, 1'b0, 32'hA000, 1'b1, "R8 train");
        req(32'h9030, 1'b1, K_IND, 1'b1, 32'hA000, "R7 table target");
        req(32'h9030, 1'b1, K_IND, 1'b0, 32'h9034, "R7 not taken");
        cfg_need_hit = 1'b1;
        req(32'h9030, 1'b1, K_IND, 1'b1, 32'h9034, "R10 indirect not installed");
        res(32'h9030, K_IND, 1'b1, 1'b1, 1'b0, 32'hB000, 1'b1, "R9 indirect install");
        req(32'h9030, 1'b0, K_DIR, 1'b1, 32'hB000, "R9 indirect hit");
        res(32'h9030, K_IND, 1'b1, 1'b0, 1'b1, 32'hC000, 1'b0, "R8 train correct");
        req(32'h9030, 1'b0, K_DIR, 1'b1, 32'hC000, "R7 table over BTB");

        // R10: pre-decode mode installs direct, never return
        cfg_need_hit = 1'b0;
        res(32'h9040, K_DIR, 1'b1, 1'b1, 1'b0, 32'hD000, 1'b1, "R11 direct miss");
        res(32'h9044, K_RET, 1'b1, 1'b1, 1'b0, 32'hE000, 1'b1, "R11 return miss");
        cfg_need_hit = 1'b1;
        req(32'h9040, 1'b0, K_DIR, 1'b1, 32'hD000, "R10 direct installed");
        req(32'h9044, 1'b0, K_DIR, 1'b1, 32'h9048, "R10 return not installed");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule